// File: doc/BRIEF.md
# Interrupt Return State Restorer

This block performs the return-from-interrupt step of a processor's exception unit. A return request carries a 3-bit kind code. The code names which saved pair supplies the resume address and the machine-state word. The block clears the state bits that a return must never restore. It then forms the resume address from the width mode of the *restored* state word, not the current one. Both values are written into the architectural instruction-address and state registers in one step.

The request side is a valid/ready stream. `req_ready` is held high at all times, so the block never applies back-pressure. A request is taken on every rising clock edge where `req_valid` is high, including back-to-back cycles. Every accepted return with a legal code does three things: it updates the registers, it raises a context-synchronising flush pulse, and it raises a pulse that clears any outstanding load-reserve address. Privilege checking of the return and the translation flush itself belong to neighbouring logic.

Top module: `rfi_restore`

## Requirements
- R1: `req_ready` is always 1. A request taken at a rising edge updates `nia_o`, `state_o` and the pulse outputs at that same edge, so they are visible in the following cycle.
- R2: State bit 18 (power-save request) of the written state word is always 0, whatever the saved word holds.
- R3: When `cfg_tgpr_en` is 1 at acceptance, state bit 17 (temporary-register bank select) of the written word is 0. When `cfg_tgpr_en` is 0, that bit is passed through unchanged.
- R4: Kind 0 (basic return) uses only bits 31:0 of its saved state word, and bits 63:32 are written as 0. Every other legal kind uses the full saved word.
- R5: The kind code selects the source pair. Kinds 0 and 1 use `std_addr`/`std_state`. Kind 2 uses `hyp_*`, kind 3 uses `crit_*`, kind 4 uses `dbg_*` and kind 5 uses `mc_*`. Kind 6 takes the address from `link_val` and the state from `count_val`.
- R6: When bit 63 (64-bit mode) of the written state word is 0, bits 63:32 of `nia_o` are 0. When that bit is 1, the upper half of the address is kept. With `HAS_64=0` the address is always cut to 32 bits.
- R7: Bits 1:0 of `nia_o` are always 0 after a return.
- R8: `flush_o` is high for exactly one cycle for each accepted legal return. Back-to-back returns give back-to-back pulses.
- R9: `resv_clr_o` pulses in the same cycle as `flush_o` for every legal return.
- R10: Kind 7 is illegal. It leaves `nia_o` and `state_o` unchanged, raises `kind_err_o` for one cycle and raises neither `flush_o` nor `resv_clr_o`.
- R11: After reset, `nia_o` and `state_o` are 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Return request strobe |
| req_ready | output | 1 | Always 1; no back-pressure |
| req_kind | input | 3 | Return kind code (0..6 legal, 7 illegal) |
| cfg_tgpr_en | input | 1 | Temporary-register-bank feature present |
| std_addr | input | XLEN | Standard saved address |
| std_state | input | XLEN | Standard saved state |
| hyp_addr | input | XLEN | Hypervisor saved address |
| hyp_state | input | XLEN | Hypervisor saved state |
| crit_addr | input | XLEN | Critical saved address |
| crit_state | input | XLEN | Critical saved state |
| dbg_addr | input | XLEN | Debug saved address |
| dbg_state | input | XLEN | Debug saved state |
| mc_addr | input | XLEN | Machine-check saved address |
| mc_state | input | XLEN | Machine-check saved state |
| link_val | input | XLEN | Link register (vectored system-call address) |
| count_val | input | XLEN | Count register (vectored system-call state) |
| nia_o | output | XLEN | Next instruction address register |
| state_o | output | XLEN | Machine-state register |
| flush_o | output | 1 | Context-synchronise flush pulse |
| resv_clr_o | output | 1 | Load-reserve invalidate pulse |
| kind_err_o | output | 1 | Illegal kind pulse |

## Verification
A wrong source select or a wrong sanitising mask shows up in `state_o` in the cycle right after acceptance. A wrong mode decision shows up one cycle after acceptance as `nia_o` with a kept or lost upper half that does not match bit 63 of the written `state_o`. A broken pulse generator shows up as a missing or stretched `flush_o` or `resv_clr_o` one cycle after the request. The bench sweeps every kind code against several address and state patterns, with the register-bank flag both on and off. Each source pair holds a different value, so a swapped pair cannot go unnoticed.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  typedef enum logic [2:0] {
    K_BASIC = 3'd0,
    K_FULL  = 3'd1,
    K_HYP   = 3'd2,
    K_CRIT  = 3'd3,
    K_DBG   = 3'd4,
    K_MC    = 3'd5,
    K_SCV   = 3'd6,
    K_BAD   = 3'd7
  } rfi_kind_e;

  localparam int unsigned HALF_W = 32;
endpackage

// File: rtl/rfi_pair_select.sv
module rfi_pair_select #(
  parameter int unsigned XLEN = 64
) (
  input  rfi_pkg::rfi_kind_e kind,
  input  logic [XLEN-1:0]    std_addr,
  input  logic [XLEN-1:0]    std_state,
  input  logic [XLEN-1:0]    hyp_addr,
  input  logic [XLEN-1:0]    hyp_state,
  input  logic [XLEN-1:0]    crit_addr,
  input  logic [XLEN-1:0]    crit_state,
  input  logic [XLEN-1:0]    dbg_addr,
  input  logic [XLEN-1:0]    dbg_state,
  input  logic [XLEN-1:0]    mc_addr,
  input  logic [XLEN-1:0]    mc_state,
  input  logic [XLEN-1:0]    link_val,
  input  logic [XLEN-1:0]    count_val,
  output logic [XLEN-1:0]    sel_addr,
  output logic [XLEN-1:0]    sel_state,
  output logic               sel_ok
);
  import rfi_pkg::*;

  always_comb begin
    sel_ok    = 1'b1;
    sel_addr  = std_addr;
    sel_state = std_state;
    unique case (kind)
      K_BASIC, K_FULL: begin
        sel_addr  = std_addr;
        sel_state = std_state;
      end
      K_HYP: begin
        sel_addr  = hyp_addr;
        sel_state = hyp_state;
      end
      K_CRIT: begin
        sel_addr  = crit_addr;
        sel_state = crit_state;
      end
      K_DBG: begin
        sel_addr  = dbg_addr;
        sel_state = dbg_state;
      end
      K_MC: begin
        sel_addr  = mc_addr;
        sel_state = mc_state;
      end
      K_SCV: begin
        sel_addr  = link_val;
        sel_state = count_val;
      end
      default: begin
        sel_ok    = 1'b0;
        sel_addr  = '0;
        sel_state = '0;
      end
    endcase
  end
endmodule

// File: rtl/rfi_state_sanitize.sv
module rfi_state_sanitize #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned POW_BIT  = 18,
  parameter int unsigned TGPR_BIT = 17,
  parameter int unsigned SF_BIT   = 63,
  parameter bit          HAS_64   = 1'b1
) (
  input  rfi_pkg::rfi_kind_e kind,
  input  logic [XLEN-1:0]    raw_state,
  input  logic               tgpr_en,
  output logic [XLEN-1:0]    clean_state,
  output logic               wide_mode
);
  import rfi_pkg::*;

  logic [XLEN-1:0] width_fixed;

  generate
    if (XLEN > HALF_W) begin : g_narrow_basic
      // The basic return restores only the low half of its saved word.
      always_comb begin
        width_fixed = raw_state;
        if (kind == K_BASIC) width_fixed[XLEN-1:HALF_W] = '0;
      end
    end else begin : g_pass
      always_comb width_fixed = raw_state;
    end
  endgenerate

  always_comb begin
    clean_state          = width_fixed;
    clean_state[POW_BIT] = 1'b0;
    if (tgpr_en) clean_state[TGPR_BIT] = 1'b0;
  end

  generate
    if (HAS_64) begin : g_mode64
      assign wide_mode = clean_state[SF_BIT];
    end else begin : g_mode32
      assign wide_mode = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rfi_target_form.sv
module rfi_target_form #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] raw_addr,
  input  logic            wide_mode,
  output logic [XLEN-1:0] target
);
  import rfi_pkg::*;

  logic [XLEN-1:0] cropped;

  generate
    if (XLEN > HALF_W) begin : g_crop
      always_comb begin
        cropped = raw_addr;
        if (!wide_mode) cropped[XLEN-1:HALF_W] = '0;
      end
    end else begin : g_nocrop
      always_comb cropped = raw_addr;
    end
  endgenerate

  always_comb begin
    target      = cropped;
    target[1:0] = 2'b00;
  end
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned POW_BIT  = 18,
  parameter int unsigned TGPR_BIT = 17,
  parameter int unsigned SF_BIT   = 63,
  parameter bit          HAS_64   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_kind,
  input  logic            cfg_tgpr_en,
  input  logic [XLEN-1:0] std_addr,
  input  logic [XLEN-1:0] std_state,
  input  logic [XLEN-1:0] hyp_addr,
  input  logic [XLEN-1:0] hyp_state,
  input  logic [XLEN-1:0] crit_addr,
  input  logic [XLEN-1:0] crit_state,
  input  logic [XLEN-1:0] dbg_addr,
  input  logic [XLEN-1:0] dbg_state,
  input  logic [XLEN-1:0] mc_addr,
  input  logic [XLEN-1:0] mc_state,
  input  logic [XLEN-1:0] link_val,
  input  logic [XLEN-1:0] count_val,
  output logic [XLEN-1:0] nia_o,
  output logic [XLEN-1:0] state_o,
  output logic            flush_o,
  output logic            resv_clr_o,
  output logic            kind_err_o
);
  import rfi_pkg::*;

  rfi_kind_e       kind;
  logic [XLEN-1:0] sel_addr, sel_state, clean_state, target;
  logic            sel_ok, wide_mode, take;

  assign kind      = rfi_kind_e'(req_kind);
  assign req_ready = 1'b1;
  assign take      = req_valid & req_ready;

  rfi_pair_select #(.XLEN(XLEN)) u_sel (
    .kind(kind),
    .std_addr(std_addr), .std_state(std_state),
    .hyp_addr(hyp_addr), .hyp_state(hyp_state),
    .crit_addr(crit_addr), .crit_state(crit_state),
    .dbg_addr(dbg_addr), .dbg_state(dbg_state),
    .mc_addr(mc_addr), .mc_state(mc_state),
    .link_val(link_val), .count_val(count_val),
    .sel_addr(sel_addr), .sel_state(sel_state), .sel_ok(sel_ok)
  );

  rfi_state_sanitize #(
    .XLEN(XLEN), .POW_BIT(POW_BIT), .TGPR_BIT(TGPR_BIT),
    .SF_BIT(SF_BIT), .HAS_64(HAS_64)
  ) u_san (
    .kind(kind), .raw_state(sel_state), .tgpr_en(cfg_tgpr_en),
    .clean_state(clean_state), .wide_mode(wide_mode)
  );

  rfi_target_form #(.XLEN(XLEN)) u_tgt (
    .raw_addr(sel_addr), .wide_mode(wide_mode), .target(target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nia_o   <= '0;
      state_o <= '0;
    end else if (take && sel_ok) begin
      nia_o   <= target;
      state_o <= clean_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o    <= 1'b0;
      resv_clr_o <= 1'b0;
      kind_err_o <= 1'b0;
    end else begin
      flush_o    <= take & sel_ok;
      resv_clr_o <= take & sel_ok;
      kind_err_o <= take & ~sel_ok;
    end
  end
endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned POW_BIT  = 18,
  parameter int unsigned TGPR_BIT = 17,
  parameter int unsigned SF_BIT   = 63
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            cfg_tgpr_en,
  input logic [XLEN-1:0] nia_o,
  input logic [XLEN-1:0] state_o,
  input logic            flush_o,
  input logic            resv_clr_o,
  input logic            kind_err_o
);
  AST_POW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !state_o[POW_BIT]); // R2
  AST_TGPR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && $past(cfg_tgpr_en)) |-> !state_o[TGPR_BIT]); // R3
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && !state_o[SF_BIT]) |-> (nia_o[XLEN-1:32] == '0)); // R6
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (nia_o[1:0] == 2'b00)); // R7
  AST_FLUSH_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(req_valid)); // R8
  AST_RESV_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clr_o == flush_o); // R9
  AST_BAD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    kind_err_o |-> ($stable(nia_o) && $stable(state_o) && !flush_o)); // R10
endmodule

bind rfi_restore rfi_restore_chk #(
  .XLEN(XLEN), .POW_BIT(POW_BIT), .TGPR_BIT(TGPR_BIT), .SF_BIT(SF_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_tgpr_en(cfg_tgpr_en),
  .nia_o(nia_o), .state_o(state_o), .flush_o(flush_o),
  .resv_clr_o(resv_clr_o), .kind_err_o(kind_err_o)
);

// File: tb/rfi_restore_bench.sv
module rfi_restore_bench;
  localparam int XL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic cfg_tgpr_en = 1'b0;
  logic [XL-1:0] a_src [0:5];
  logic [XL-1:0] s_src [0:5];
  logic [XL-1:0] nia_o, state_o;
  logic flush_o, resv_clr_o, kind_err_o;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rfi_restore u_rfi_restore (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cfg_tgpr_en(cfg_tgpr_en),
    .std_addr(a_src[0]), .std_state(s_src[0]),
    .hyp_addr(a_src[1]), .hyp_state(s_src[1]),
    .crit_addr(a_src[2]), .crit_state(s_src[2]),
    .dbg_addr(a_src[3]), .dbg_state(s_src[3]),
    .mc_addr(a_src[4]), .mc_state(s_src[4]),
    .link_val(a_src[5]), .count_val(s_src[5]),
    .nia_o(nia_o), .state_o(state_o), .flush_o(flush_o),
    .resv_clr_o(resv_clr_o), .kind_err_o(kind_err_o)
  );

  task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pair_of(input int k);
    return (k <= 1) ? 0 : k - 1;
  endfunction

  initial begin
    logic [XL-1:0] exp_n, exp_s, prev_n, prev_s, st, ad;
    for (int k = 0; k < 6; k++) begin
      a_src[k] = '0;
      s_src[k] = '0;
    end
    #1;
    chk("R11 nia reset", nia_o, '0);
    chk("R11 state reset", state_o, '0);
    chk("R11 pulses reset", {61'd0, flush_o, resv_clr_o, kind_err_o}, '0);
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev_n = '0;
    prev_s = '0;
    for (int t = 0; t < 2; t++) begin
      for (int p = 0; p < 8; p++) begin
        for (int kind = 0; kind < 8; kind++) begin
          for (int k = 0; k < 6; k++) begin
            a_src[k] = (64'hA5C3_0000_1234_5677 ^ (64'(p) * 64'h0101_0101_0000_0011))
                       ^ (64'(k + 1) << 40) ^ (64'(k) << 4);
            s_src[k] = 64'h0000_0000_0006_0000 ^ (64'(p) * 64'h0010_0000_0100_0005)
                       ^ (64'(k) << 8) ^ (64'(k & 1) << 17);
            s_src[k][63] = p[0];
            if (k == 2) s_src[k][18] = 1'b1;
          end
          cfg_tgpr_en = t[0];
          req_kind = 3'(kind);
          req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
          if (kind == 7) begin
            chk("R10 nia kept", nia_o, prev_n);
            chk("R10 state kept", state_o, prev_s);
            chk("R10 err pulse", {63'd0, kind_err_o}, 64'd1);
            chk("R10 no flush", {62'd0, flush_o, resv_clr_o}, '0);
          end else begin
            st = s_src[pair_of(kind)];
            ad = a_src[pair_of(kind)];
            if (kind == 0) st = st & 64'h0000_0000_FFFF_FFFF; // R4
            st[18] = 1'b0;                                    // R2
            if (t == 1) st[17] = 1'b0;                        // R3
            if (!st[63]) ad = ad & 64'h0000_0000_FFFF_FFFF;   // R6
            ad[1:0] = 2'b00;                                  // R7
            exp_n = ad;
            exp_s = st;
            chk("R5 R2 R3 R4 state", state_o, exp_s);
            chk("R5 R6 R7 nia", nia_o, exp_n);
            chk("R8 flush", {63'd0, flush_o}, 64'd1);
            chk("R9 resv clr", {63'd0, resv_clr_o}, 64'd1);
            prev_n = exp_n;
            prev_s = exp_s;
          end
          @(negedge clk);
          chk("R8 flush one cycle", {62'd0, flush_o, kind_err_o}, '0);
        end
      end
    end
    // back-to-back returns: one pulse per return (R8)
    req_kind = 3'd1;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R8 b2b first", {63'd0, flush_o}, 64'd1);
    @(negedge clk);
    chk("R8 b2b second", {63'd0, flush_o}, 64'd1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 b2b end", {63'd0, flush_o}, 64'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule